// File: doc/BRIEF.md
# Receive Buffer with Per-Character Line-Error Tags

This block sits between a UART's receive shift logic and the host bus. Each incoming character arrives with three line-error flags: parity, framing and break. The block stores the character and its flags together in one entry. The oldest entry is always presented as the holding register. The error flags of that head entry drive three bits of a line status word, so the host always sees the errors that belong to the byte it is about to take. Reading the holding register advances the head, and the status bits follow in the next cycle.

A mode input selects between a 64-entry queue and a single holding register of depth one. Dropping the mode input, or pulsing the flush input, discards everything stored. A write to a full buffer is dropped and latches an overrun flag, which stays set until the status word is read. A fill-level output goes to trigger and flow-control logic elsewhere.

Top module: `rx_tag_fifo`

## Requirements
- R1: With `fifo_en_i` high the buffer holds up to 64 entries, each one being an 8-bit character plus 3 tag bits, and it does not lose any of them.
- R2: `hold_data_o` presents the oldest stored character, and a pulse on `rd_data_i` advances it to the next one in arrival order.
- R3: `lsr_o[2]`, `lsr_o[3]` and `lsr_o[4]` carry the head entry's `wr_err_i[0]` (parity), `wr_err_i[1]` (framing) and `wr_err_i[2]` (break). They take the next entry's flags in the cycle after a read, and they are zero while the buffer is empty.
- R4: `lsr_o[0]` (data ready) is high exactly when at least one entry is stored.
- R5: A write while the buffer is full, with no read in the same cycle, is discarded, the stored contents are left unchanged, and `lsr_o[1]` (overrun) is set.
- R6: A pulse on `lsr_rd_i` clears the overrun flag. If an overrunning write happens in the same cycle, the flag stays set.
- R7: With `fifo_en_i` low the capacity is one entry, so a second write before a read overruns.
- R8: A high-to-low change of `fifo_en_i` empties the buffer.
- R9: A pulse on `rx_flush_i` empties the buffer and clears the head error bits.
- R10: A read while the buffer is empty has no effect.
- R11: A read and a write in the same cycle on a full buffer are both accepted: the level stays at capacity and no overrun is raised.
- R12: `level_o` gives the number of stored entries, from 0 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| rx_flush_i | input | 1 | Pulse that empties the buffer |
| wr_valid_i | input | 1 | A character with its flags is presented for storage |
| wr_data_i | input | 8 | Received character |
| wr_err_i | input | 3 | Error flags: bit 0 parity, bit 1 framing, bit 2 break |
| rd_data_i | input | 1 | Host read of the holding register; pops the head |
| lsr_rd_i | input | 1 | Host read of the status word; clears overrun |
| hold_data_o | output | 8 | Head character |
| lsr_o | output | 5 | Status: 0 data ready, 1 overrun, 4:2 head error flags |
| level_o | output | 7 | Number of stored entries |

## Verification
The buffer is first filled completely with characters whose values and tag patterns both change from entry to entry, and is then drained. Because of this, a reordered entry, an off-by-one pointer or a swapped tag bit each produces a distinct mismatch. Overruns are driven three ways: alone, together with a status read, and together with a read of the holding register. This separates the order in which the overrun flag is set and cleared from the case where a write is accepted because the read frees a slot. Flushes, a mode drop while data is stored, reads of an empty buffer and the depth-one mode show whether the capacity and the clearing of the head flags depend on the mode.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned TAG_W  = 3;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_tag_store.sv
module rx_tag_store
  import rx_tag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic      clk_i,
  input  logic      we_i,
  input  logic [AW-1:0] waddr_i,
  input  rx_entry_t wentry_i,
  input  logic [AW-1:0] raddr_i,
  output rx_entry_t rentry_o
);
  rx_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wentry_i;
  end

  assign rentry_o = mem_q[raddr_i];
endmodule

// File: rtl/rx_tag_ctrl.sv
module rx_tag_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] cap_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          we_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic full, do_pop, do_push;

  assign empty_o = (lvl_q == '0);
  assign full    = (lvl_q >= cap_i);
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  // a pop in the same cycle frees the slot the write needs
  assign do_push = push_i & (~full | do_pop) & ~flush_i;
  assign ovf_o   = push_i & full & ~do_pop & ~flush_i;
  assign we_o    = do_push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign level_o  = lvl_q;
endmodule

// File: rtl/rx_tag_status.sv
module rx_tag_status
  import rx_tag_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovf_i,
  input  logic             lsr_rd_i,
  input  logic             empty_i,
  input  logic [TAG_W-1:0] head_tag_i,
  output logic [4:0]       lsr_o
);
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (ovf_i)    ovr_q <= 1'b1;  // a new overrun beats the clearing read
    else if (lsr_rd_i) ovr_q <= 1'b0;
  end

  assign lsr_o = {empty_i ? '0 : head_tag_i, ovr_q, ~empty_i};
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rx_tag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              rx_flush_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAG_W-1:0]  wr_err_i,
  input  logic              rd_data_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] hold_data_o,
  output logic [4:0]        lsr_o,
  output logic [LW-1:0]     level_o
);
  logic fifo_en_q, flush, we, ovf, empty;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cap;
  rx_entry_t wentry, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_en_q <= 1'b0;
    else         fifo_en_q <= fifo_en_i;
  end

  assign flush  = rx_flush_i | (fifo_en_q & ~fifo_en_i);
  assign cap    = fifo_en_i ? LW'(DEPTH) : LW'(1);
  assign wentry = '{tag: wr_err_i, data: wr_data_i};

  rx_tag_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(wr_valid_i), .pop_i(rd_data_i),
    .cap_i(cap), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .level_o(level_o),
    .empty_o(empty), .we_o(we), .ovf_o(ovf)
  );

  rx_tag_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .we_i(we), .waddr_i(wr_ptr), .wentry_i(wentry),
    .raddr_i(rd_ptr), .rentry_o(head)
  );

  rx_tag_status u_status (
    .clk_i, .rst_ni, .ovf_i(ovf), .lsr_rd_i, .empty_i(empty),
    .head_tag_i(head.tag), .lsr_o
  );

  assign hold_data_o = head.data;
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          fifo_en_q,
  input logic          rx_flush_i,
  input logic          wr_valid_i,
  input logic          rd_data_i,
  input logic          lsr_rd_i,
  input logic [4:0]    lsr_o,
  input logic [LW-1:0] level_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  p_level_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL);

  p_tags_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == '0 |-> lsr_o[4:2] == '0);

  p_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[0] == (level_o != '0));

  p_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && fifo_en_q && level_o == FULL && wr_valid_i && !rd_data_i && !rx_flush_i
    |=> lsr_o[1] && level_o == FULL);

  p_ovr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !wr_valid_i |=> !lsr_o[1]);

  p_single_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && !fifo_en_q |-> level_o <= LW'(1));

  p_mode_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_q && !fifo_en_i |=> level_o == '0);

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> level_o == '0 && lsr_o[4:2] == '0);

  p_empty_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == '0 && rd_data_i && !wr_valid_i |=> level_o == '0);

  p_full_rw_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && fifo_en_q && level_o == FULL && wr_valid_i && rd_data_i && !rx_flush_i
    |=> level_o == FULL && !$rose(lsr_o[1]));
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .fifo_en_i, .fifo_en_q, .rx_flush_i, .wr_valid_i,
  .rd_data_i, .lsr_rd_i, .lsr_o, .level_o
);

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, flush = 1'b0, wr_v = 1'b0, rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] wr_d = '0;
  logic [2:0] wr_e = '0;
  logic [7:0] hold;
  logic [4:0] lsr;
  logic [6:0] level;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rx_tag_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .rx_flush_i(flush),
    .wr_valid_i(wr_v), .wr_data_i(wr_d), .wr_err_i(wr_e), .rd_data_i(rd),
    .lsr_rd_i(lsr_rd), .hold_data_o(hold), .lsr_o(lsr), .level_o(level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of controls at a negedge, release at the next one
  task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] e,
                     input bit r, input bit s, input bit f);
    @(negedge clk);
    wr_v = w; wr_d = d; wr_e = e; rd = r; lsr_rd = s; flush = f;
    @(negedge clk);
    wr_v = 0; rd = 0; lsr_rd = 0; flush = 0;
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) cyc(1, 8'(base + i * 5), 3'(i % 8), 0, 0, 0);
  endtask

  task automatic t_reset();
    chk(level == 0, "R12 reset level", level, 0);
    chk(lsr == 0, "R4 reset status", lsr, 0);
  endtask

  task automatic t_fill_drain();
    bit ok = 1;
    fill(64, 3);
    chk(level == 64, "R1 level after 64 writes", level, 64);
    chk(lsr[0] == 1, "R4 data ready", lsr[0], 1);
    cyc(1, 8'hEE, 3'd7, 0, 0, 0);
    chk(lsr[1] == 1, "R5 overrun set", lsr[1], 1);
    chk(level == 64, "R5 level unchanged", level, 64);
    cyc(0, 0, 0, 0, 1, 0);
    chk(lsr[1] == 0, "R6 overrun cleared by status read", lsr[1], 0);
    for (int i = 0; i < 64; i++) begin
      if (hold != 8'(3 + i * 5)) begin
        ok = 0; chk(0, "R2 head data order", hold, 8'(3 + i * 5));
      end
      if (lsr[4:2] != 3'(i % 8)) begin
        ok = 0; chk(0, "R3 head tags", lsr[4:2], i % 8);
      end
      cyc(0, 0, 0, 1, 0, 0);
    end
    chk(ok, "R2 R3 all 64 entries in order with tags", ok, 1);
    chk(level == 0 && lsr == 0, "R3 empty clears tags", lsr, 0);
  endtask

  task automatic t_empty_read();
    cyc(0, 0, 0, 1, 0, 0);
    chk(level == 0, "R10 empty read ignored", level, 0);
    cyc(1, 8'h5A, 3'b010, 0, 0, 0);
    chk(hold == 8'h5A && lsr == 5'b01001, "R10 write after empty read", {hold, 3'b0, lsr}, {8'h5A, 8'h09});
    cyc(0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_full_rw();
    fill(64, 0);
    cyc(1, 8'h99, 3'b100, 1, 0, 0);
    chk(level == 64, "R11 level stays full", level, 64);
    chk(lsr[1] == 0, "R11 no overrun", lsr[1], 0);
    chk(hold == 8'd5 && lsr[4:2] == 3'd1, "R3 head advanced after read", {hold, 5'b0, lsr[4:2]}, {8'd5, 8'd1});
    for (int i = 0; i < 63; i++) cyc(0, 0, 0, 1, 0, 0);
    chk(hold == 8'h99 && lsr[4:2] == 3'b100, "R11 write accepted at tail", {hold, 5'b0, lsr[4:2]}, {8'h99, 8'h04});
    cyc(1, 8'h11, 0, 0, 0, 0);
  endtask

  task automatic t_set_wins();
    fill(63, 0);
    cyc(1, 8'h22, 0, 0, 1, 0);
    chk(lsr[1] == 1, "R6 set wins over clear", lsr[1], 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk(lsr[1] == 0, "R6 cleared afterwards", lsr[1], 0);
  endtask

  task automatic t_flush();
    cyc(0, 0, 0, 0, 0, 1);
    chk(level == 0 && lsr == 0, "R9 flush empties", {level, lsr}, 0);
  endtask

  task automatic t_single();
    fill(5, 0);
    @(negedge clk); fifo_en = 0;
    @(negedge clk);
    chk(level == 0 && lsr[0] == 0, "R8 mode drop empties", level, 0);
    cyc(1, 8'hA1, 3'b001, 0, 0, 0);
    cyc(1, 8'hB2, 3'b000, 0, 0, 0);
    chk(level == 1 && lsr[1] == 1, "R7 depth one overrun", {level, lsr[1]}, {7'd1, 1'b1});
    chk(hold == 8'hA1 && lsr[4:2] == 3'b001, "R7 first byte kept", hold, 8'hA1);
    cyc(0, 0, 0, 1, 1, 0);
    chk(level == 0 && lsr == 0, "R7 read empties single", {level, lsr}, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    fifo_en = 1;
    @(negedge clk);
    t_fill_drain();
    t_empty_read();
    t_full_rw();
    t_set_wins();
    t_flush();
    t_single();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule